// File: doc/BRIEF.md
# Serial Flash Write-Enable Latch Controller

This block is the command front end of a serial-flash-style SPI slave. While chip select is held low it collects opcode bits from the serial data input on each rising serial clock edge, most significant bit first. When chip select returns high it decodes the most recent byte, provided the frame held a whole, non-zero number of bytes. All serial inputs are brought into the system clock domain through two-flop synchronizers before any edge is detected.

A single write-enable latch gates the four modifying commands: page program, sector erase, bulk erase and write status register. Each decoded modifying command produces a one-cycle accept strobe when the latch was set, or a one-cycle reject strobe when it was clear, along with a code naming the command. The array engine reports completion of a modifying operation on a done input tagged with the same code, and that completion clears the latch. The latch is also cleared by the disable opcode and by reset. The serial output is never driven by this block.

Top module: `sfl_wel_ctrl`

## Requirements
- R1: After reset the latch output is 0, both strobes are 0 and the serial output enable is 0.
- R2: A complete frame whose decoded byte is 8'h06 sets the latch to 1.
- R3: A complete frame whose decoded byte is 8'h04 clears the latch to 0.
- R4: A complete frame decoding to 8'h02, 8'hD8, 8'hC7 or 8'h01 while the latch is 1 gives exactly one accept strobe of one cycle, no reject strobe, leaves the latch unchanged, and sets the kind output to 0, 1, 2 or 3 respectively.
- R5: The same four opcodes while the latch is 0 give exactly one reject strobe, no accept strobe, the same kind code, and leave the latch at 0.
- R6: A one-cycle pulse on the done input with any kind code 0 to 3 clears the latch on the next clock edge.
- R7: A frame ending after fewer than 8 bits, or after a bit count that is not a multiple of 8, changes nothing; a frame of 16 bits is decoded from its last 8 bits.
- R8: Bits are taken most significant first; the bit-reversed form of a command byte is not that command.
- R9: Frames work identically with the serial clock idling low (mode 0) or high (mode 3), sampling the data input on rising edges.
- R10: Any byte other than the six listed leaves the latch unchanged and produces no strobe.
- R11: The serial output enable stays 0 at all times, including throughout set and clear frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, asynchronous to clk |
| cs_n_i | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out (held 0) |
| so_oe_o | output | 1 | Serial output enable (held 0) |
| done_i | input | 1 | Array engine completion pulse |
| done_kind_i | input | 2 | Kind code of the completed operation |
| wel_o | output | 1 | Write-enable latch state |
| acc_o | output | 1 | One-cycle accept strobe |
| rej_o | output | 1 | One-cycle reject strobe |
| kind_o | output | 2 | Kind code of the last decoded modifying command |

## Verification
A chip-select rise reaches the latch and strobes on the fourth rising clock edge after it: two synchronizer stages, the frame register, then the state register; a done pulse acts on the next edge. The bench waits eight clock cycles after every chip-select rise, and two after a done pulse, before it samples at a falling edge, so every result has settled. Strobes are counted at every falling edge, so a one-cycle pulse is seen exactly once and a check compares count deltas per frame. An exhaustive sweep over all 256 bytes, from both latch states and alternating serial modes, computes the expected latch and strobe counts arithmetically.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
    localparam int OPW = 8;

    localparam logic [OPW-1:0] OPC_SET  = 8'h06;
    localparam logic [OPW-1:0] OPC_CLR  = 8'h04;
    localparam logic [OPW-1:0] OPC_PROG = 8'h02;
    localparam logic [OPW-1:0] OPC_SECT = 8'hD8;
    localparam logic [OPW-1:0] OPC_BULK = 8'hC7;
    localparam logic [OPW-1:0] OPC_STAT = 8'h01;

    typedef enum logic [1:0] {
        K_PROG = 2'd0,
        K_SECT = 2'd1,
        K_BULK = 2'd2,
        K_STAT = 2'd3
    } mod_kind_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_MOD  = 2'd3
    } dec_act_e;

    typedef struct packed {
        dec_act_e  act;
        mod_kind_e kind;
    } dec_t;
endpackage

// File: rtl/sfl_sync.sv
module sfl_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sfl_shifter.sv
module sfl_shifter #(
    parameter int OPW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sck_s,
    input  logic           cs_n_s,
    input  logic           si_s,
    output logic           frame_o,
    output logic [OPW-1:0] op_o
);
    localparam int CW = (OPW > 1) ? $clog2(OPW) : 1;
    localparam logic [CW-1:0] LAST = CW'(OPW - 1);

    typedef struct packed {
        logic           sck_p;
        logic           cs_p;
        logic [OPW-1:0] sh;
        logic [CW-1:0]  cnt;
        logic           full;
        logic           frame;
        logic [OPW-1:0] op;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic   sck_rise, cs_rise;

    always_comb begin
        st_d       = st_q;
        st_d.frame = 1'b0;
        st_d.sck_p = sck_s;
        st_d.cs_p  = cs_n_s;
        sck_rise   = sck_s & ~st_q.sck_p;
        cs_rise    = cs_n_s & ~st_q.cs_p;
        if (cs_n_s) begin
            st_d.cnt  = '0;
            st_d.full = 1'b0;
            if (cs_rise && st_q.full && st_q.cnt == '0) begin
                st_d.frame = 1'b1;
                st_d.op    = st_q.sh;
            end
        end else if (sck_rise) begin
            st_d.sh = {st_q.sh[OPW-2:0], si_s};
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.full = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.cs_p  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_o = st_q.frame;
    assign op_o    = st_q.op;

    // R7: a frame strobe lasts one cycle and only follows a chip-select release
    a_r7_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |=> !frame_o);
    a_r7_frame_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |-> st_q.cs_p);
endmodule

// File: rtl/sfl_decode.sv
module sfl_decode
    import sfl_pkg::*;
(
    input  logic [OPW-1:0] op_i,
    output dec_t           dec_o
);
    always_comb begin
        dec_o.act  = ACT_NONE;
        dec_o.kind = K_PROG;
        case (op_i)
            OPC_SET:  dec_o.act = ACT_SET;
            OPC_CLR:  dec_o.act = ACT_CLR;
            OPC_PROG: begin dec_o.act = ACT_MOD; dec_o.kind = K_PROG; end
            OPC_SECT: begin dec_o.act = ACT_MOD; dec_o.kind = K_SECT; end
            OPC_BULK: begin dec_o.act = ACT_MOD; dec_o.kind = K_BULK; end
            OPC_STAT: begin dec_o.act = ACT_MOD; dec_o.kind = K_STAT; end
            default:  dec_o.act = ACT_NONE;
        endcase
    end
endmodule

// File: rtl/sfl_wel_ctrl.sv
module sfl_wel_ctrl
    import sfl_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] CLR_MASK    = 4'b1111
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_i,
    input  logic       cs_n_i,
    input  logic       si_i,
    output logic       so_o,
    output logic       so_oe_o,
    input  logic       done_i,
    input  logic [1:0] done_kind_i,
    output logic       wel_o,
    output logic       acc_o,
    output logic       rej_o,
    output logic [1:0] kind_o
);
    typedef struct packed {
        logic      wel;
        logic      acc;
        logic      rej;
        mod_kind_e kind;
    } ctl_st_t;

    logic [2:0]     sync_s;
    logic           frame;
    logic [OPW-1:0] op;
    dec_t           dec;
    ctl_st_t        ctl_d, ctl_q;

    sfl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sck_i, cs_n_i, si_i}),
        .q_o   (sync_s)
    );

    sfl_shifter #(.OPW(OPW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (sync_s[2]),
        .cs_n_s  (sync_s[1]),
        .si_s    (sync_s[0]),
        .frame_o (frame),
        .op_o    (op)
    );

    sfl_decode u_dec (
        .op_i  (op),
        .dec_o (dec)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.acc = 1'b0;
        ctl_d.rej = 1'b0;
        if (done_i && CLR_MASK[done_kind_i]) ctl_d.wel = 1'b0;
        if (frame) begin
            case (dec.act)
                ACT_SET: ctl_d.wel = 1'b1;
                ACT_CLR: ctl_d.wel = 1'b0;
                ACT_MOD: begin
                    ctl_d.kind = dec.kind;
                    if (ctl_q.wel) ctl_d.acc = 1'b1;
                    else           ctl_d.rej = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign wel_o   = ctl_q.wel;
    assign acc_o   = ctl_q.acc;
    assign rej_o   = ctl_q.rej;
    assign kind_o  = ctl_q.kind;
    assign so_o    = 1'b0;
    assign so_oe_o = 1'b0;

    a_r2_set_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (frame && dec.act == ACT_SET) |=> wel_o);
    a_r3_clear_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (frame && dec.act == ACT_CLR) |=> !wel_o);
    a_r4_accept_gated: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |-> $past(wel_o));
    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_o && rej_o));
    a_r5_reject_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rej_o |-> !$past(wel_o));
    a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !(frame && dec.act == ACT_SET)) |=> !wel_o);
    a_r10_quiet_without_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame |=> (!acc_o && !rej_o));
    a_r10_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame && !done_i) |=> $stable(wel_o));
endmodule

// File: tb/sfl_wel_ctrl_tb_top.sv
module sfl_wel_ctrl_tb_top;
    localparam int CLK_P = 10;
    localparam int HALF  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic       done = 1'b0;
    logic [1:0] done_kind = 2'd0;
    logic       so, so_oe, wel, acc, rej;
    logic [1:0] kind;

    int n_run = 0, n_fail = 0;
    int n_acc = 0, n_rej = 0, n_oe = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sfl_wel_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
        .so_o(so), .so_oe_o(so_oe), .done_i(done), .done_kind_i(done_kind),
        .wel_o(wel), .acc_o(acc), .rej_o(rej), .kind_o(kind)
    );

    always @(negedge clk) begin
        if (acc)   n_acc++;
        if (rej)   n_rej++;
        if (so_oe) n_oe++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // pat is consumed from bit 15 downward; m3 selects a high idle clock
    task automatic send(input logic [15:0] pat, input int n, input bit m3);
        sck = m3;
        wait_n(HALF);
        cs_n = 1'b0;
        wait_n(HALF);
        for (int i = 0; i < n; i++) begin
            if (m3) sck = 1'b0;
            si = pat[15-i];
            wait_n(HALF);
            sck = 1'b1;
            wait_n(HALF);
            if (!m3) sck = 1'b0;
        end
        wait_n(HALF);
        cs_n = 1'b1;
        wait_n(8);
    endtask

    function automatic int kind_of(input logic [7:0] v);
        case (v)
            8'h02: return 0;
            8'hD8: return 1;
            8'hC7: return 2;
            8'h01: return 3;
            default: return -1;
        endcase
    endfunction

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int a0, r0, ew, k;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(3);
        // R1: reset state
        chk("R1 latch after reset", wel, 0);
        chk("R1 strobes after reset", n_acc + n_rej, 0);
        chk("R1 output enable after reset", so_oe, 0);

        // R5 then R2: reject with latch clear, then set it
        send({8'h02, 8'h00}, 8, 1'b0);
        chk("R5 program rejected count", n_rej, 1);
        chk("R5 program no accept", n_acc, 0);
        send({8'h06, 8'h00}, 8, 1'b0);
        chk("R2 set latch", wel, 1);

        // R6: completion of each kind clears the latch
        for (int kk = 0; kk < 4; kk++) begin
            send({8'h06, 8'h00}, 8, kk[0]);
            chk("R6 latch set before done", wel, 1);
            done_kind = 2'(kk);
            done = 1'b1;
            wait_n(1);
            done = 1'b0;
            wait_n(2);
            chk($sformatf("R6 done kind %0d clears", kk), wel, 0);
        end

        // R7: truncated or ragged frames from a clear latch
        for (int n = 1; n < 16; n++) begin
            if (n == 8) continue;
            send(16'h0606, n, n[0]);
            chk($sformatf("R7 %0d-bit set frame ignored", n), wel, 0);
        end
        send(16'h0006, 16, 1'b1);
        chk("R7 16-bit frame uses last byte", wel, 1);
        for (int n = 1; n < 16; n++) begin
            if (n == 8) continue;
            send(16'h0404, n, n[0]);
            chk($sformatf("R7 %0d-bit clear frame ignored", n), wel, 1);
        end

        // R2 R3 R4 R5 R8 R9 R10: every byte from both latch states, both modes
        for (int v = 0; v < 256; v++) begin
            for (int pre = 0; pre < 2; pre++) begin
                send({(pre != 0) ? 8'h06 : 8'h04, 8'h00}, 8, 1'b0);
                a0 = n_acc;
                r0 = n_rej;
                send({8'(v), 8'h00}, 8, bit'(v[0] ^ pre[0]));
                k  = kind_of(8'(v));
                ew = pre;
                if (v == 8'h06) ew = 1;
                if (v == 8'h04) ew = 0;
                if (k >= 0) begin
                    chk($sformatf("R4 R5 R9 byte %02h pre %0d accept", v, pre), n_acc - a0, pre);
                    chk($sformatf("R4 R5 R9 byte %02h pre %0d reject", v, pre), n_rej - r0, 1 - pre);
                    chk($sformatf("R4 R5 byte %02h kind", v), kind, k);
                end else begin
                    chk($sformatf("R10 R8 byte %02h pre %0d no strobe", v, pre), (n_acc - a0) + (n_rej - r0), 0);
                end
                chk($sformatf("R2 R3 R10 R9 byte %02h pre %0d latch", v, pre), wel, ew);
            end
        end

        // R11: output enable never asserted
        chk("R11 output enable never high", n_oe, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule